// File: doc/BRIEF.md
# Programmable-Width Port Register Matrix

This block sits between sixteen handshake port controllers (eight that receive, eight that send) and a shared bank of bidirectional data registers. Each register bit carries a small configuration entry naming the one port that owns it, so the width of every port is decided at run time by how many bits are given to it, up to a fixed per-port cap. When a controller raises its enable, all bits owned by that port act together in one clock edge. Bits owned by a receiving port capture from that port's channel. Bits owned by a sending port load from the core side and appear on that port's channel.

Channel data is packed: lane k of a port's channel word corresponds to the k-th register bit, counted upward in register index, that the port owns. The block keeps a count of owned bits per port. It flags any port whose count is over the cap and disables that port's enable until the configuration is fixed. Configuration can only change while every enable is low, so the width of a port never shifts during a transfer.

Top module: `gals_port_matrix`

## Requirements
- R1: After reset every configuration entry is unassigned, and `reg_q`, `dir_out`, `out_data`, `port_over` and `cfg_err` are all zero.
- R2: A configuration write (`cfg_we` high, with `in_en` and `out_en` all low) sets entry `cfg_addr` to owner `cfg_port` with flag `cfg_valid`, and the entry takes effect from the next clock edge. Owner codes 0 to 7 name receive ports 0 to 7. Codes 8 to 15 name send ports 0 to 7.
- R3: A configuration write made while any bit of `in_en` or `out_en` is high is ignored.
- R4: At an edge where `in_en[p]` is high, each bit owned by receive port p loads `in_data[p*64+k]`, where k is the number of bits owned by p that have a lower register index.
- R5: At an edge where `out_en[p]` is high, each bit i owned by send port p loads `core_wdata[i]`. At all times, `out_data[p*64+k]` shows the k-th bit owned by send port p, counted upward in register index. Lanes with no owner read 0.
- R6: `dir_out[i]` is 1 exactly when bit i holds a valid assignment to a send port.
- R7: A bit with no valid assignment keeps its value, never appears on `out_data`, and has `dir_out` low.
- R8: A port that owns more than 64 bits has its `port_over` flag set (bit index equals the owner code), `cfg_err` goes high, and that port's enable has no effect on any bit.
- R9: A port that owns exactly 64 bits is legal: no over flag is set, and all 64 lanes transfer.
- R10: Enables of different ports that are high in the same cycle all act at that same edge, each on its own bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Register bit whose entry is written |
| cfg_valid | input | 1 | Assignment valid flag written into the entry |
| cfg_port | input | 4 | Owner code: 0-7 receive ports, 8-15 send ports |
| in_en | input | 8 | Latch enables from the receive controllers |
| in_data | input | 512 | Packed channel words of the receive ports, 64 lanes each |
| out_en | input | 8 | Launch enables from the send controllers |
| core_wdata | input | 128 | Core-side values loaded into send-owned bits |
| out_data | output | 512 | Packed channel words of the send ports, 64 lanes each |
| reg_q | output | 128 | Current contents of the data register bank |
| dir_out | output | 128 | Per-bit drive direction, 1 means it drives a send channel |
| port_over | output | 16 | Per-owner flag for a port that owns too many bits |
| cfg_err | output | 1 | Set while any port is over the cap |

## Verification
Configuration writes and data loads take one register stage. Their effect on `reg_q`, `dir_out`, `port_over` and `cfg_err` is due right after the edge that samples the strobe. `out_data` follows `reg_q` and the configuration combinationally, in that same cycle. The bench drives inputs on the falling edge. It updates its reference model from the values present at the rising edge, then compares every output on the next falling edge, so each result is read exactly one edge after its stimulus.

// File: rtl/gals_port_matrix_pkg.sv
// Package: shared constants and the per-bit configuration entry type.
// Assumes a fixed split of eight receive and eight send controllers,
// addressed by a 4-bit owner code whose top bit selects the direction.
package gals_port_matrix_pkg;

    localparam int NUM_IN_PORTS  = 8;
    localparam int NUM_OUT_PORTS = 8;
    localparam int NUM_OWNERS    = NUM_IN_PORTS + NUM_OUT_PORTS;
    localparam int OWNER_W       = $clog2(NUM_OWNERS);
    localparam int LANE_W        = OWNER_W - 1;

    // One configuration entry per data register bit.
    typedef struct packed {
        logic               vld;
        logic [OWNER_W-1:0] owner;
    } bit_cfg_t;

endpackage

// File: rtl/gpm_cfg_store.sv
// Configuration storage: one entry per register bit.
// Writes land only while no port enable is active (busy low).
// Assumes cfg_addr is always below NUM_BITS.
module gpm_cfg_store
    import gals_port_matrix_pkg::*;
#(
    parameter int NUM_BITS = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [$clog2(NUM_BITS)-1:0] addr,
    input  logic                        wvalid,
    input  logic [OWNER_W-1:0]          wowner,
    input  logic                        busy,
    output bit_cfg_t                    cfg_q [NUM_BITS]
);

    localparam int ENTRY_W = OWNER_W + 1;

    // Entry update: clear on reset, write when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BITS; i++) cfg_q[i] <= '0;
        end else if (we && !busy) begin
            cfg_q[addr] <= '{vld: wvalid, owner: wowner};
        end
    end

    // Flattened view of all entries for the guard below.
    logic [NUM_BITS*ENTRY_W-1:0] cfg_flat;
    always_comb begin
        for (int i = 0; i < NUM_BITS; i++) cfg_flat[i*ENTRY_W +: ENTRY_W] = cfg_q[i];
    end

    // R3: a write during an active transfer leaves every entry unchanged.
    a_r3_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (we && busy) |=> $stable(cfg_flat));

endmodule

// File: rtl/gpm_rank_map.sv
// Ownership map: counts the bits owned by each port, gives every bit
// its lane number inside its port (ascending register index), and
// flags ports whose count exceeds the cap. Pure combinational logic.
module gpm_rank_map
    import gals_port_matrix_pkg::*;
#(
    parameter int NUM_BITS = 128,
    parameter int PORT_CAP = 64
) (
    input  bit_cfg_t                         cfg [NUM_BITS],
    output logic [$clog2(NUM_BITS+1)-1:0]    rank [NUM_BITS],
    output logic [NUM_OWNERS-1:0]            over,
    output logic [NUM_BITS-1:0]              blocked
);

    localparam int CNT_W = $clog2(NUM_BITS + 1);
    localparam logic [CNT_W-1:0] CAP_C = CNT_W'(PORT_CAP);

    logic [CNT_W-1:0] cnt [NUM_OWNERS];

    // Running per-owner count across bits: lane number and totals.
    always_comb begin
        for (int p = 0; p < NUM_OWNERS; p++) cnt[p] = '0;
        for (int i = 0; i < NUM_BITS; i++) begin
            rank[i] = '0;
            if (cfg[i].vld) begin
                rank[i]           = cnt[cfg[i].owner];
                cnt[cfg[i].owner] = cnt[cfg[i].owner] + CNT_W'(1);
            end
        end
    end

    // Over-cap flag per owner.
    always_comb begin
        for (int p = 0; p < NUM_OWNERS; p++) over[p] = (cnt[p] > CAP_C);
    end

    // Bits whose owner is over the cap must not be touched.
    always_comb begin
        for (int i = 0; i < NUM_BITS; i++) blocked[i] = cfg[i].vld && over[cfg[i].owner];
    end

endmodule

// File: rtl/gpm_bit_bank.sv
// Data register bank with per-bit enable fan-out and direction.
// A bit follows its owner's enable: receive owners capture channel
// lane rank[i], send owners load core_wdata[i]. Send-owned bits are
// gathered back into packed channel words. Assumes rank/blocked come
// from the ownership map of the same configuration.
module gpm_bit_bank
    import gals_port_matrix_pkg::*;
#(
    parameter int NUM_BITS = 128,
    parameter int PORT_CAP = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  bit_cfg_t                          cfg [NUM_BITS],
    input  logic [$clog2(NUM_BITS+1)-1:0]     rank [NUM_BITS],
    input  logic [NUM_BITS-1:0]               blocked,
    input  logic [NUM_IN_PORTS-1:0]           in_en,
    input  logic [NUM_IN_PORTS*PORT_CAP-1:0]  in_data,
    input  logic [NUM_OUT_PORTS-1:0]          out_en,
    input  logic [NUM_BITS-1:0]               core_wdata,
    output logic [NUM_BITS-1:0]               q,
    output logic [NUM_BITS-1:0]               dir,
    output logic [NUM_OUT_PORTS*PORT_CAP-1:0] out_data
);

    localparam int RANK_W  = $clog2(NUM_BITS + 1);
    localparam int LANES_W = $clog2(NUM_IN_PORTS * PORT_CAP);
    localparam logic [RANK_W-1:0] CAP_R = RANK_W'(PORT_CAP);

    logic [NUM_BITS-1:0] fire;
    logic [NUM_BITS-1:0] nxt;
    logic [NUM_BITS-1:0] vld_v;

    // Per-bit enable selection, next value and direction.
    for (genvar g = 0; g < NUM_BITS; g++) begin : g_bit
        logic [OWNER_W-1:0] own;
        logic [LANE_W-1:0]  lane;
        logic               is_send;
        logic               in_range;
        logic [LANES_W-1:0] idx;
        assign own      = cfg[g].owner;
        assign lane     = own[LANE_W-1:0];
        assign is_send  = own[OWNER_W-1];
        assign in_range = (rank[g] < CAP_R);
        assign idx      = LANES_W'(int'(lane) * PORT_CAP + int'(rank[g]));
        assign vld_v[g] = cfg[g].vld;
        assign fire[g]  = cfg[g].vld && !blocked[g] &&
                          (is_send ? out_en[lane] : in_en[lane]);
        assign nxt[g]   = is_send ? core_wdata[g] : (in_range && in_data[idx]);
        assign dir[g]   = cfg[g].vld && is_send;
    end

    // Register bank: load enabled bits, hold the rest.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (nxt & fire) | (q & ~fire);
    end

    // Gather send-owned bits into packed channel words.
    always_comb begin
        out_data = '0;
        for (int i = 0; i < NUM_BITS; i++) begin
            if (cfg[i].vld && cfg[i].owner[OWNER_W-1] && rank[i] < CAP_R) begin
                out_data[LANES_W'(int'(cfg[i].owner[LANE_W-1:0]) * PORT_CAP + int'(rank[i]))] = q[i];
            end
        end
    end

    // R7: bits with no valid owner never change.
    a_r7_unassigned_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((q ^ $past(q)) & ~$past(vld_v)) == '0));

    // R8: bits whose owner is over the cap never change.
    a_r8_blocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((q ^ $past(q)) & $past(blocked)) == '0));

endmodule

// File: rtl/gals_port_matrix.sv
// Top: programmable-width port register matrix. Joins configuration
// storage, the ownership map and the data bank. Assumes the port
// controllers hold their enables high for one cycle per transfer.
module gals_port_matrix
    import gals_port_matrix_pkg::*;
#(
    parameter int NUM_BITS = 128,
    parameter int PORT_CAP = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [$clog2(NUM_BITS)-1:0]       cfg_addr,
    input  logic                              cfg_valid,
    input  logic [OWNER_W-1:0]                cfg_port,
    input  logic [NUM_IN_PORTS-1:0]           in_en,
    input  logic [NUM_IN_PORTS*PORT_CAP-1:0]  in_data,
    input  logic [NUM_OUT_PORTS-1:0]          out_en,
    input  logic [NUM_BITS-1:0]               core_wdata,
    output logic [NUM_OUT_PORTS*PORT_CAP-1:0] out_data,
    output logic [NUM_BITS-1:0]               reg_q,
    output logic [NUM_BITS-1:0]               dir_out,
    output logic [NUM_OWNERS-1:0]             port_over,
    output logic                              cfg_err
);

    localparam int RANK_W = $clog2(NUM_BITS + 1);

    bit_cfg_t            cfg_q [NUM_BITS];
    logic [RANK_W-1:0]   rank  [NUM_BITS];
    logic [NUM_BITS-1:0] blocked;
    logic                busy;

    // Any active enable freezes the configuration.
    assign busy = (|in_en) || (|out_en);

    gpm_cfg_store #(.NUM_BITS(NUM_BITS)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wvalid (cfg_valid),
        .wowner (cfg_port),
        .busy   (busy),
        .cfg_q  (cfg_q)
    );

    gpm_rank_map #(.NUM_BITS(NUM_BITS), .PORT_CAP(PORT_CAP)) u_map (
        .cfg     (cfg_q),
        .rank    (rank),
        .over    (port_over),
        .blocked (blocked)
    );

    gpm_bit_bank #(.NUM_BITS(NUM_BITS), .PORT_CAP(PORT_CAP)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg_q),
        .rank       (rank),
        .blocked    (blocked),
        .in_en      (in_en),
        .in_data    (in_data),
        .out_en     (out_en),
        .core_wdata (core_wdata),
        .q          (reg_q),
        .dir        (dir_out),
        .out_data   (out_data)
    );

    // Error summary over all owners.
    assign cfg_err = |port_over;

    // R6: bit directions only change after an idle cycle.
    a_r6_dir_change_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out != $past(dir_out)) |-> ($past(in_en) == '0 && $past(out_en) == '0));

endmodule

// File: tb/sim_gals_port_matrix.sv
`timescale 1ns/1ps
module sim_gals_port_matrix;

    localparam int NB  = 128;
    localparam int CAP = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [6:0]     cfg_addr = '0;
    logic           cfg_valid = 1'b0;
    logic [3:0]     cfg_port = '0;
    logic [7:0]     in_en = '0;
    logic [8*CAP-1:0] in_data = '0;
    logic [7:0]     out_en = '0;
    logic [NB-1:0]  core_wdata = '0;
    logic [8*CAP-1:0] out_data;
    logic [NB-1:0]  reg_q;
    logic [NB-1:0]  dir_out;
    logic [15:0]    port_over;
    logic           cfg_err;

    always #2 clk = ~clk;

    gals_port_matrix #(.NUM_BITS(NB), .PORT_CAP(CAP)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_valid(cfg_valid), .cfg_port(cfg_port), .in_en(in_en),
        .in_data(in_data), .out_en(out_en), .core_wdata(core_wdata),
        .out_data(out_data), .reg_q(reg_q), .dir_out(dir_out),
        .port_over(port_over), .cfg_err(cfg_err)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference model state.
    logic       mvld  [NB];
    logic [3:0] mport [NB];
    logic       mq    [NB];
    int         mrank [NB];
    int         mcnt  [16];

    function automatic void mrecalc();
        for (int p = 0; p < 16; p++) mcnt[p] = 0;
        for (int i = 0; i < NB; i++) begin
            mrank[i] = 0;
            if (mvld[i]) begin
                mrank[i] = mcnt[mport[i]];
                mcnt[mport[i]]++;
            end
        end
    endfunction

    // One clock: model follows the values present at the rising edge.
    task automatic tick();
        bit acc;
        @(posedge clk);
        mrecalc();
        acc = cfg_we && in_en == 0 && out_en == 0;
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin mvld[i] = 0; mport[i] = 0; mq[i] = 0; end
        end else begin
            for (int i = 0; i < NB; i++) begin
                if (mvld[i]) begin
                    int p = mport[i];
                    if (p < 8 && in_en[p] && mcnt[p] <= CAP) mq[i] = in_data[p*CAP + mrank[i]];
                    if (p >= 8 && out_en[p-8] && mcnt[p] <= CAP) mq[i] = core_wdata[i];
                end
            end
            if (acc) begin mvld[cfg_addr] = cfg_valid; mport[cfg_addr] = cfg_port; end
        end
        @(negedge clk);
    endtask

    task automatic check(string tag);
        logic [NB-1:0]    eq, ed;
        logic [8*CAP-1:0] eo;
        logic [15:0]      ev;
        mrecalc();
        eq = '0; ed = '0; eo = '0;
        for (int i = 0; i < NB; i++) begin
            eq[i] = mq[i];
            ed[i] = mvld[i] && mport[i] >= 8;
            if (ed[i] && mrank[i] < CAP) eo[(mport[i]-8)*CAP + mrank[i]] = mq[i];
        end
        for (int p = 0; p < 16; p++) ev[p] = mcnt[p] > CAP;
        n_chk += 4;
        if (reg_q !== eq) begin n_fail++; $display("FAIL %s reg_q act=%h exp=%h", tag, reg_q, eq); end
        if (dir_out !== ed) begin n_fail++; $display("FAIL %s dir_out act=%h exp=%h", tag, dir_out, ed); end
        if (out_data !== eo) begin n_fail++; $display("FAIL %s out_data act=%h exp=%h", tag, out_data, eo); end
        if ({port_over, cfg_err} !== {ev, |ev}) begin
            n_fail++; $display("FAIL %s over/err act=%h/%b exp=%h/%b", tag, port_over, cfg_err, ev, |ev);
        end
    endtask

    task automatic cfg_write(int a, bit v, int p);
        cfg_we = 1; cfg_addr = 7'(a); cfg_valid = v; cfg_port = 4'(p);
        tick();
        cfg_we = 0;
    endtask

    task automatic fire(logic [7:0] ie, logic [7:0] oe, logic [31:0] seed);
        in_en = ie; out_en = oe; in_data = {16{seed}}; core_wdata = {4{~seed}};
        tick();
        in_en = '0; out_en = '0;
    endtask

    typedef struct packed { logic [7:0] ie; logic [7:0] oe; logic [31:0] seed; } vec_t;
    localparam vec_t VECS [8] = '{
        '{8'h01, 8'h00, 32'hA5A5_0F0F},
        '{8'hFF, 8'h00, 32'h1234_5678},
        '{8'h00, 8'h01, 32'hDEAD_BEEF},
        '{8'h00, 8'hFF, 32'h0F1E_2D3C},
        '{8'h5A, 8'hA5, 32'hCAFE_F00D},
        '{8'h80, 8'h80, 32'h8001_7FFE},
        '{8'hFF, 8'hFF, 32'h0000_0000},
        '{8'h33, 8'hCC, 32'hFFFF_FFFF}
    };

    initial begin
        for (int i = 0; i < NB; i++) begin mvld[i] = 0; mport[i] = 0; mq[i] = 0; end
        @(negedge clk);
        tick(); tick();
        rst_n = 1;
        check("R1 reset");

        // Scattered ownership: bit i -> owner i%16, some bits unassigned.
        for (int i = 0; i < NB; i++) cfg_write(i, (i % 17) != 5, i % 16);
        check("R2 R6 R7 config");

        // Table walk: R4 receive capture, R5 send launch, R10 concurrency, R7 hold.
        for (int v = 0; v < 8; v++) begin
            fire(VECS[v].ie, VECS[v].oe, VECS[v].seed);
            check("R4 R5 R7 R10 table");
        end

        // R3: write during an active enable is ignored (bit 3 stays receive).
        in_en = 8'h01; in_data = {16{32'h5555_AAAA}};
        cfg_we = 1; cfg_addr = 7'd3; cfg_valid = 1; cfg_port = 4'd9;
        tick();
        cfg_we = 0; in_en = '0;
        check("R3 blocked write");
        fire(8'h08, 8'h00, 32'h7777_1111);
        check("R3 owner kept");

        // R9: exactly 64 bits on receive port 1.
        for (int i = 0; i < NB; i++) cfg_write(i, 0, 0);
        for (int i = 0; i < 64; i++) cfg_write(i * 2, 1, 1);
        check("R9 full width legal");
        fire(8'h02, 8'h00, 32'h9C3A_61E5);
        check("R9 R4 full width capture");

        // R8: a 65th bit puts port 1 over the cap, its enable is suppressed.
        cfg_write(1, 1, 1);
        check("R8 over flag");
        fire(8'h02, 8'h00, 32'h0123_4567);
        check("R8 suppressed enable");

        // R8 on a send port: 65 bits to send port 0 (owner 8).
        for (int i = 0; i < 65; i++) cfg_write(i * 2 - (i == 64 ? 127 : 0), 1, 8);
        check("R8 send over flag");
        fire(8'h00, 8'h01, 32'h3333_CCCC);
        check("R8 send suppressed");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule